// File: doc/BRIEF.md
# Serial Command Receiver and Decoder

This block takes 8-bit commands from a host over a three-wire serial link (a select line, a shift clock and a data line) and turns them into control state for a disc-drive servo front end. While select is high, each rising edge of the shift clock moves one data bit into a shift register, least significant bit first. When select falls, the captured frame is kept. It runs on the next tick of a slow internal timebase. That tick is divided down from the block's own clock, so host timing never drives the decode logic directly.

A decoded command either changes a persistent mode (laser, focus loop, tracking loop, sled loop, spindle disc-size mode) or fires a one-cycle start pulse toward a sequencer (focus search, focus/track offset trims, E/F balance). Two command codes stay held after they run, so a later empty select pulse runs them again until a clear code is sent. A pair of codes opens a mask that hides the payload of two-byte transfers from the decoder until a closing code arrives.

Top module: `sercmd_top`

## Requirements
- R1: Serial bits are shifted in on rising edges of `hostClk` while `hostCe` is high. The first bit received becomes bit 0 of the command.
- R2: A command takes effect only after `hostCe` falls, aligned to the internal tick (one every `TICK_DIV` clocks). No output changes while select is high.
- R3: A frame of 1 to 7 bits, or of more than 8 bits, is dropped. It changes no mode and fires no pulse.
- R4: Code 0x94 sets `laserOn` and `focusOn`. Code 0x95 sets `focusOn` and leaves the laser unchanged. Code 0x96 clears both.
- R5: Codes 0x9E and 0x9D set and clear `trackOn`. Codes 0x9A and 0x9B set and clear `sledOn`.
- R6: `spindleMode` is 0 for off (0x99), 1 for small disc (0x97) and 2 for large disc (0x98). It never takes the value 3.
- R7: `seqPulse` is high for exactly one clock per executed command, with at most one bit set. The bits are: bit0 focus search (0x08), bit1 focus-offset trim start (0x90), bit2 focus-offset trim cancel (0x91), bit3 track-offset trim start (0x92), bit4 track-offset trim cancel (0x93), bit5 E/F balance start (0x9C).
- R8: After 0x08 or 0x9C, an empty frame (select pulse with no clocks) runs that code again. Any other full frame, including 0xFE, ends the hold. An empty frame with no held code does nothing.
- R9: Codes 0xF0 and 0xF8 open a mask. While it is open, every full frame other than 0xFF, and every empty frame, is ignored. 0xFF closes the mask.
- R10: Code 0x00 returns all modes to their reset values, clears the held code and closes the mask.
- R11: Codes not listed above leave every mode unchanged and fire no pulse.
- R12: After reset all mode outputs are 0, `spindleMode` is 0 and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the source of the internal tick |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCe | input | 1 | Host select; frame open while high |
| hostClk | input | 1 | Host shift clock |
| hostDat | input | 1 | Host serial data, LSB first |
| laserOn | output | 1 | Laser drive enable |
| focusOn | output | 1 | Focus loop closed |
| trackOn | output | 1 | Tracking loop closed |
| sledOn | output | 1 | Sled loop enabled |
| spindleMode | output | 2 | 0 off, 1 small disc, 2 large disc |
| seqPulse | output | 6 | One-cycle sequencer start pulses |

## Verification
The bench sweeps every byte value twice, in two different orders, so that mask and hold state carry from one code to the next. A reference model predicts the mode outputs and the pulse counts. A receiver that shifted MSB first would put the sled and spindle codes on the wrong outputs. A decoder acting while select was still high would show the sled mode changing early. Short and long frames check that the length counter really gates execution. Empty frames after held and non-held codes catch a hold register that is never cleared or is replayed when it should not be. Reset and mask codes sent during an open mask catch a mask that leaks the payload through.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
  localparam int CMD_W   = 8;
  localparam int PULSE_N = 6;

  typedef enum logic [1:0] {
    SPIN_OFF   = 2'd0,
    SPIN_SMALL = 2'd1,
    SPIN_LARGE = 2'd2
  } spinMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic consume;
  } dpCtrl_t;

  // datapath -> control status
  typedef struct packed {
    logic frameReady;
  } dpStat_t;

  localparam logic [CMD_W-1:0] CODE_RESET     = 8'h00;
  localparam logic [CMD_W-1:0] CODE_FSEARCH   = 8'h08;
  localparam logic [CMD_W-1:0] CODE_FOFS_GO   = 8'h90;
  localparam logic [CMD_W-1:0] CODE_FOFS_STOP = 8'h91;
  localparam logic [CMD_W-1:0] CODE_TOFS_GO   = 8'h92;
  localparam logic [CMD_W-1:0] CODE_TOFS_STOP = 8'h93;
  localparam logic [CMD_W-1:0] CODE_LASER_ON  = 8'h94;
  localparam logic [CMD_W-1:0] CODE_FOCUS_ON  = 8'h95;
  localparam logic [CMD_W-1:0] CODE_LASER_OFF = 8'h96;
  localparam logic [CMD_W-1:0] CODE_SPIN_SM   = 8'h97;
  localparam logic [CMD_W-1:0] CODE_SPIN_LG   = 8'h98;
  localparam logic [CMD_W-1:0] CODE_SPIN_OFF  = 8'h99;
  localparam logic [CMD_W-1:0] CODE_SLED_ON   = 8'h9A;
  localparam logic [CMD_W-1:0] CODE_SLED_OFF  = 8'h9B;
  localparam logic [CMD_W-1:0] CODE_BALANCE   = 8'h9C;
  localparam logic [CMD_W-1:0] CODE_TRK_OFF   = 8'h9D;
  localparam logic [CMD_W-1:0] CODE_TRK_ON    = 8'h9E;
  localparam logic [CMD_W-1:0] CODE_MASK_A    = 8'hF0;
  localparam logic [CMD_W-1:0] CODE_MASK_B    = 8'hF8;
  localparam logic [CMD_W-1:0] CODE_UNMASK    = 8'hFF;

  localparam int P_FSEARCH   = 0;
  localparam int P_FOFS_GO   = 1;
  localparam int P_FOFS_STOP = 2;
  localparam int P_TOFS_GO   = 3;
  localparam int P_TOFS_STOP = 4;
  localparam int P_BALANCE   = 5;
endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sercmd_shift.sv
module sercmd_shift
  import sercmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostCe,
  input  logic             hostClk,
  input  logic             hostDat,
  input  dpCtrl_t          ctrl,
  output dpStat_t          stat,
  output logic [CMD_W-1:0] frameByte,
  output logic [CNT_W-1:0] frameLen
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(CMD_W + 1);

  logic [2:0] synOut;
  logic ceS, clkS, datS;
  logic cePrev, clkPrev;
  logic [CMD_W-1:0] shiftReg;
  logic [CNT_W-1:0] bitCnt;
  logic frameReady;

  sercmd_sync #(.STAGES(SYNC_STAGES), .W(3)) sync_i (
    .clk (clk),
    .rstN(rstN),
    .d   ({hostCe, hostClk, hostDat}),
    .q   (synOut)
  );

  assign ceS  = synOut[2];
  assign clkS = synOut[1];
  assign datS = synOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cePrev     <= 1'b0;
      clkPrev    <= 1'b0;
      shiftReg   <= '0;
      bitCnt     <= '0;
      frameByte  <= '0;
      frameLen   <= '0;
      frameReady <= 1'b0;
    end else begin
      cePrev  <= ceS;
      clkPrev <= clkS;
      if (ceS && !cePrev) begin
        shiftReg <= '0;
        bitCnt   <= '0;
      end else if (ceS && clkS && !clkPrev) begin
        shiftReg <= {datS, shiftReg[CMD_W-1:1]};
        if (bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
      end
      if (!ceS && cePrev) begin
        frameByte  <= shiftReg;
        frameLen   <= bitCnt;
        frameReady <= 1'b1;
      end else if (ctrl.consume) begin
        frameReady <= 1'b0;
      end
    end
  end

  assign stat.frameReady = frameReady;
endmodule

// File: rtl/sercmd_ctrl.sv
module sercmd_ctrl
  import sercmd_pkg::*;
#(
  parameter int TICK_DIV = 32,
  parameter int CNT_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStat_t            stat,
  input  logic [CMD_W-1:0]   frameByte,
  input  logic [CNT_W-1:0]   frameLen,
  output dpCtrl_t            ctrl,
  output logic               laserOn,
  output logic               focusOn,
  output logic               trackOn,
  output logic               sledOn,
  output logic [1:0]         spindleMode,
  output logic [PULSE_N-1:0] seqPulse
);
  localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0]    TICK_LAST = TW'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] FULL_LEN  = CNT_W'(CMD_W);

  logic [TW-1:0] tickCnt;
  logic tick, exec;

  logic maskOn, heldValid;
  logic [CMD_W-1:0] heldCode;
  spinMode_e spinQ;

  logic fullFrame, emptyFrame, runValid, newFrame, unmask;
  logic [CMD_W-1:0] runCode;
  logic nLaser, nFocus, nTrack, nSled, nMask, nHeldV;
  logic [CMD_W-1:0] nHeldC;
  spinMode_e nSpin;
  logic [PULSE_N-1:0] nPulse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickCnt <= '0;
    else if (tickCnt == TICK_LAST) tickCnt <= '0;
    else tickCnt <= tickCnt + 1'b1;
  end

  assign tick         = (tickCnt == TICK_LAST);
  assign exec         = stat.frameReady && tick;
  assign ctrl.consume = exec;

  // frame classification
  always_comb begin
    fullFrame  = (frameLen == FULL_LEN);
    emptyFrame = (frameLen == '0);
    runValid   = 1'b0;
    newFrame   = 1'b0;
    unmask     = 1'b0;
    runCode    = frameByte;
    if (exec) begin
      if (fullFrame) begin
        if (maskOn) begin
          unmask = (frameByte == CODE_UNMASK);
        end else begin
          runValid = 1'b1;
          newFrame = 1'b1;
        end
      end else if (emptyFrame && heldValid && !maskOn) begin
        runValid = 1'b1;
        runCode  = heldCode;
      end
    end
  end

  // command decode
  always_comb begin
    nLaser = laserOn;
    nFocus = focusOn;
    nTrack = trackOn;
    nSled  = sledOn;
    nSpin  = spinQ;
    nMask  = maskOn && !unmask;
    nPulse = '0;
    nHeldV = heldValid;
    nHeldC = heldCode;
    if (runValid) begin
      case (runCode)
        CODE_RESET: begin
          nLaser = 1'b0;
          nFocus = 1'b0;
          nTrack = 1'b0;
          nSled  = 1'b0;
          nSpin  = SPIN_OFF;
          nMask  = 1'b0;
        end
        CODE_FSEARCH:   nPulse[P_FSEARCH]   = 1'b1;
        CODE_FOFS_GO:   nPulse[P_FOFS_GO]   = 1'b1;
        CODE_FOFS_STOP: nPulse[P_FOFS_STOP] = 1'b1;
        CODE_TOFS_GO:   nPulse[P_TOFS_GO]   = 1'b1;
        CODE_TOFS_STOP: nPulse[P_TOFS_STOP] = 1'b1;
        CODE_BALANCE:   nPulse[P_BALANCE]   = 1'b1;
        CODE_LASER_ON: begin
          nLaser = 1'b1;
          nFocus = 1'b1;
        end
        CODE_FOCUS_ON:  nFocus = 1'b1;
        CODE_LASER_OFF: begin
          nLaser = 1'b0;
          nFocus = 1'b0;
        end
        CODE_SPIN_SM:   nSpin  = SPIN_SMALL;
        CODE_SPIN_LG:   nSpin  = SPIN_LARGE;
        CODE_SPIN_OFF:  nSpin  = SPIN_OFF;
        CODE_SLED_ON:   nSled  = 1'b1;
        CODE_SLED_OFF:  nSled  = 1'b0;
        CODE_TRK_OFF:   nTrack = 1'b0;
        CODE_TRK_ON:    nTrack = 1'b1;
        CODE_MASK_A, CODE_MASK_B: nMask = 1'b1;
        default: ;
      endcase
    end
    if (newFrame) begin
      nHeldV = (runCode == CODE_FSEARCH) || (runCode == CODE_BALANCE);
      nHeldC = runCode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laserOn   <= 1'b0;
      focusOn   <= 1'b0;
      trackOn   <= 1'b0;
      sledOn    <= 1'b0;
      spinQ     <= SPIN_OFF;
      maskOn    <= 1'b0;
      heldValid <= 1'b0;
      heldCode  <= '0;
      seqPulse  <= '0;
    end else begin
      laserOn   <= nLaser;
      focusOn   <= nFocus;
      trackOn   <= nTrack;
      sledOn    <= nSled;
      spinQ     <= nSpin;
      maskOn    <= nMask;
      heldValid <= nHeldV;
      heldCode  <= nHeldC;
      seqPulse  <= nPulse;
    end
  end

  assign spindleMode = spinQ;
endmodule

// File: rtl/sercmd_top.sv
module sercmd_top
  import sercmd_pkg::*;
#(
  parameter int TICK_DIV    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostCe,
  input  logic               hostClk,
  input  logic               hostDat,
  output logic               laserOn,
  output logic               focusOn,
  output logic               trackOn,
  output logic               sledOn,
  output logic [1:0]         spindleMode,
  output logic [PULSE_N-1:0] seqPulse
);
  localparam int CNT_W = $clog2(CMD_W + 2);

  dpCtrl_t          dpCtrl;
  dpStat_t          dpStat;
  logic [CMD_W-1:0] frameByte;
  logic [CNT_W-1:0] frameLen;

  sercmd_shift #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) shift_i (
    .clk      (clk),
    .rstN     (rstN),
    .hostCe   (hostCe),
    .hostClk  (hostClk),
    .hostDat  (hostDat),
    .ctrl     (dpCtrl),
    .stat     (dpStat),
    .frameByte(frameByte),
    .frameLen (frameLen)
  );

  sercmd_ctrl #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .stat       (dpStat),
    .frameByte  (frameByte),
    .frameLen   (frameLen),
    .ctrl       (dpCtrl),
    .laserOn    (laserOn),
    .focusOn    (focusOn),
    .trackOn    (trackOn),
    .sledOn     (sledOn),
    .spindleMode(spindleMode),
    .seqPulse   (seqPulse)
  );
endmodule

// File: rtl/sercmd_chk.sv
module sercmd_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hostCe,
  input logic       laserOn,
  input logic       focusOn,
  input logic       trackOn,
  input logic       sledOn,
  input logic [1:0] spindleMode,
  input logic [5:0] seqPulse
);
  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(seqPulse)); // R7

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (seqPulse != 6'd0) |=> (seqPulse == 6'd0)); // R7

  AST_SPIN_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    spindleMode != 2'd3); // R6

  AST_QUIET_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (hostCe && $past(hostCe)) |-> ($stable({laserOn, focusOn, trackOn, sledOn, spindleMode})
                                  && seqPulse == 6'd0)); // R2

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> ({laserOn, focusOn, trackOn, sledOn, spindleMode, seqPulse} == '0)); // R12
endmodule

bind sercmd_top sercmd_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .hostCe     (hostCe),
  .laserOn    (laserOn),
  .focusOn    (focusOn),
  .trackOn    (trackOn),
  .sledOn     (sledOn),
  .spindleMode(spindleMode),
  .seqPulse   (seqPulse)
);

// File: tb/sercmd_top_tb_top.sv
`timescale 1ns/1ps
module sercmd_top_tb_top;
  localparam int TICK = 32;
  localparam int LOW_WAIT = 4 * TICK + 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCe = 1'b0, hostClk = 1'b0, hostDat = 1'b0;
  logic laserOn, focusOn, trackOn, sledOn;
  logic [1:0] spindleMode;
  logic [5:0] seqPulse;

  int testCnt = 0;
  int failCnt = 0;
  int gotCnt [6];
  int expCnt [6];
  logic eLaser, eFocus, eTrack, eSled, eMask, eHeldV;
  logic [1:0] eSpin;
  logic [7:0] eHeldC;

  always #2.5 clk = ~clk;

  sercmd_top #(.TICK_DIV(TICK), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .hostCe(hostCe), .hostClk(hostClk), .hostDat(hostDat),
    .laserOn(laserOn), .focusOn(focusOn), .trackOn(trackOn), .sledOn(sledOn),
    .spindleMode(spindleMode), .seqPulse(seqPulse)
  );

  always @(negedge clk) begin
    for (int k = 0; k < 6; k++) if (rstN && seqPulse[k]) gotCnt[k]++;
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic applyCode(input logic [7:0] c);
    case (c)
      8'h00: begin eLaser = 0; eFocus = 0; eTrack = 0; eSled = 0; eSpin = 0; eMask = 0; end
      8'h08: expCnt[0]++;
      8'h90: expCnt[1]++;
      8'h91: expCnt[2]++;
      8'h92: expCnt[3]++;
      8'h93: expCnt[4]++;
      8'h9C: expCnt[5]++;
      8'h94: begin eLaser = 1; eFocus = 1; end
      8'h95: eFocus = 1;
      8'h96: begin eLaser = 0; eFocus = 0; end
      8'h97: eSpin = 2'd1;
      8'h98: eSpin = 2'd2;
      8'h99: eSpin = 2'd0;
      8'h9A: eSled = 1;
      8'h9B: eSled = 0;
      8'h9D: eTrack = 0;
      8'h9E: eTrack = 1;
      8'hF0, 8'hF8: eMask = 1;
      default: ;
    endcase
  endtask

  task automatic modelFrame(input logic [7:0] c, input int len);
    if (len == 8) begin
      if (eMask) begin
        if (c == 8'hFF) eMask = 0;
      end else begin
        applyCode(c);
        eHeldV = (c == 8'h08) || (c == 8'h9C);
        eHeldC = c;
      end
    end else if (len == 0) begin
      if (eHeldV && !eMask) applyCode(eHeldC);
    end
  endtask

  task automatic openFrame();
    hostCe = 1'b1;
    waitN(6);
  endtask

  task automatic shiftBits(input logic [7:0] c, input int len);
    for (int i = 0; i < len; i++) begin
      hostDat = c[i % 8];   // R1: first bit is bit 0
      hostClk = 1'b0; waitN(4);
      hostClk = 1'b1; waitN(4);
      hostClk = 1'b0;
    end
    waitN(4);
  endtask

  task automatic closeFrame(input logic [7:0] c, input int len);
    hostCe = 1'b0;
    waitN(LOW_WAIT);
    modelFrame(c, len);
  endtask

  task automatic sendFrame(input logic [7:0] c, input int len);
    openFrame();
    shiftBits(c, len);
    closeFrame(c, len);
  endtask

  task automatic checkState(input string req);
    logic [5:0] got, exp;
    got = {laserOn, focusOn, trackOn, sledOn, spindleMode};
    exp = {eLaser, eFocus, eTrack, eSled, eSpin};
    testCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s modes {laser,focus,track,sled,spin} got %b expected %b", req, got, exp);
    end
  endtask

  task automatic checkPulses(input string req);
    testCnt++;
    for (int k = 0; k < 6; k++) begin
      if (gotCnt[k] != expCnt[k]) begin
        failCnt++;
        $display("FAIL %s pulse bit %0d count got %0d expected %0d", req, k, gotCnt[k], expCnt[k]);
        break;
      end
    end
  endtask

  function automatic string reqOf(input logic [7:0] c, input logic masked);
    if (masked) return "R9";
    case (c)
      8'h94, 8'h95, 8'h96: return "R4";
      8'h9A, 8'h9B, 8'h9D, 8'h9E: return "R5";
      8'h97, 8'h98, 8'h99: return "R6";
      8'h08, 8'h90, 8'h91, 8'h92, 8'h93, 8'h9C: return "R7";
      8'hF0, 8'hF8, 8'hFF: return "R9";
      8'h00: return "R10";
      default: return "R11";
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [7:0] c;
    string tag;
    for (int k = 0; k < 6; k++) begin gotCnt[k] = 0; expCnt[k] = 0; end
    eLaser = 0; eFocus = 0; eTrack = 0; eSled = 0; eSpin = 0;
    eMask = 0; eHeldV = 0; eHeldC = 0;
    waitN(5);
    rstN = 1'b1;
    waitN(5);

    // R12: reset state
    checkState("R12");
    checkPulses("R12");

    // R2: nothing happens while select is still high
    openFrame();
    shiftBits(8'h9A, 8);
    waitN(4 * TICK);
    checkState("R2");
    closeFrame(8'h9A, 8);
    checkState("R2");

    // R3: short and long frames dropped
    sendFrame(8'h9B, 7);
    checkState("R3");
    sendFrame(8'h9B, 9);
    checkState("R3");
    sendFrame(8'h08, 3);
    checkPulses("R3");

    // R8: held replay and clear
    sendFrame(8'h08, 8);
    sendFrame(8'h00, 0);
    checkPulses("R8");
    sendFrame(8'hFE, 8);
    sendFrame(8'h00, 0);
    checkPulses("R8");
    sendFrame(8'h9C, 8);
    sendFrame(8'h00, 0);
    sendFrame(8'h00, 0);
    checkPulses("R8");
    sendFrame(8'h90, 8);
    sendFrame(8'h00, 0);
    checkPulses("R8");

    // R9: mask hides payload, including reset code
    sendFrame(8'h94, 8);
    sendFrame(8'hF8, 8);
    sendFrame(8'h9B, 8);
    sendFrame(8'h00, 8);
    checkState("R9");
    sendFrame(8'hFF, 8);
    sendFrame(8'h9B, 8);
    checkState("R9");

    // R10: reset code returns power-on modes
    sendFrame(8'h9E, 8);
    sendFrame(8'h98, 8);
    sendFrame(8'h00, 8);
    checkState("R10");

    // R1 R4..R11: full byte sweeps with carried state
    for (int i = 0; i < 256; i++) begin
      c = 8'(i);
      tag = reqOf(c, eMask);
      sendFrame(c, 8);
      checkState(tag);
      checkPulses(tag);
    end
    for (int i = 0; i < 256; i++) begin
      c = 8'((i * 167 + 59) % 256);
      tag = reqOf(c, eMask);
      sendFrame(c, 8);
      checkState(tag);
      checkPulses(tag);
    end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule